// File: doc/BRIEF.md
# Packed-Symbol ECC Correction Applier

This block sits behind a Reed-Solomon decoder that works on 12-bit code symbols. For each page, the decoder delivers up to four corrections. Each correction is a symbol position and a 12-bit error pattern. The block turns each correction into XOR updates on a byte-addressed page buffer. It carries out every update as a read-modify-write cycle on the buffer's single port.

The buffer is one linear byte space. It holds a 2048-byte main area, followed by a spare area that begins at address 2048. The 14 parity bytes occupy spare offsets 0 to 13, which are addresses 2048 to 2061.

Symbols are packed across the page as a bit stream, most significant bit first. Symbol 0 is a short 8-bit symbol that covers byte 0 alone. Every later symbol covers 12 bits, so it touches either a full byte and half of the next, or half a byte and the full next byte. Symbol 1365 straddles the main/spare boundary. Positions beyond the last parity byte cannot exist in a page. A correction that names such a position, or that carries bits into the missing upper nibble of symbol 0, makes the page uncorrectable. Corrections arrive on a valid/ready handshake, and a last marker closes each page. When the page closes, the block pulses a done strobe together with the number of corrections applied and a fail flag.

Top module: `ecc_fix_apply`

## Requirements
- R1: `corr_ready` is high only while the block is waiting for a correction. After a valid correction is accepted, `corr_ready` is low in the next cycle. After an illegal correction without the last marker, it stays high.
- R2: Position 0 with a pattern no larger than 0xFF XORs the pattern's low 8 bits into byte 0. No other byte changes.
- R3: Position 0 with any pattern bit above bit 7 set raises the fail flag, and the buffer is not written.
- R4: For odd position p, byte floor(3p/2) is XORed with pattern[11:4]. Byte floor(3p/2)+1 is XORed with pattern[3:0] placed in bits 7:4.
- R5: For even position p > 0, byte floor(3p/2)-1 is XORed with pattern[11:8] in bits 3:0. Byte floor(3p/2) is XORed with pattern[7:0].
- R6: Position 1365 updates main byte 2047 with pattern[11:4]. It updates spare byte 0 (address 2048) with pattern[3:0] in bits 7:4.
- R7: Positions 1366 to 1374 address the spare area at address 2048 plus the spare offset. Position 1374 reaches spare offsets 12 and 13.
- R8: A position above 1374 raises the fail flag, and the buffer is not written.
- R9: After the correction carrying the last marker has been processed, `done` is high for exactly one cycle. In that cycle, `fixed_cnt` gives the number of corrections applied and `page_fail` the fail flag. Both are zero again for the next page, and `done` follows even when the last correction is illegal.
- R10: A correction beyond the fourth in one page is not applied and raises the fail flag. `fixed_cnt` never exceeds 4.
- R11: Every buffer write goes to the address read in the previous cycle. The written value is the read value XOR the mask, so bits and bytes outside the correction keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_valid | input | 1 | Correction offered |
| corr_ready | output | 1 | Block can take a correction |
| corr_pos | input | 11 | Symbol position |
| corr_pat | input | 12 | Error pattern |
| corr_last | input | 1 | Marks the final correction of a page |
| buf_addr | output | 12 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe, data returned next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle page completion strobe |
| page_fail | output | 1 | Page uncorrectable, valid with done |
| fixed_cnt | output | 3 | Corrections applied, valid with done |

## Verification
Every position from 0 to 1380 is swept as a one-correction page. After each page, the whole buffer is compared with a model that places each pattern bit arithmetically in the packed bit stream.

The sweep catches the following faults:
- Mixing up the odd and even split puts nibbles in the wrong half of a byte.
- Breaking the boundary symbol 1365 corrupts byte 2047 or spare byte 0.
- An off-by-one in the position limit writes past the parity bytes or rejects position 1374.

Further pages check the remaining cases:
- Symbol 0 with an upper-nibble pattern.
- Repeated corrections at the same symbol, which must cancel.
- A fifth correction, which must be dropped.
- An illegal last correction, which must still end the page with done.

A design that wrote without reading first would clobber untouched bits.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int SYM_W        = 12;
    localparam int POS_W        = 11;
    localparam int MAIN_BYTES   = 2048;
    localparam int SPARE_BYTES  = 64;
    localparam int PARITY_BYTES = 14;
    localparam int BUF_BYTES    = MAIN_BYTES + SPARE_BYTES;
    localparam int ADDR_W       = $clog2(BUF_BYTES);
    // highest symbol whose bits still fall inside main + parity bytes
    localparam int LAST_POS     = ((MAIN_BYTES + PARITY_BYTES) * 8 - 8) / SYM_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr0;
        logic [7:0]        mask0;
        logic [ADDR_W-1:0] addr1;
        logic [7:0]        mask1;
        logic              two;
        logic              bad;
    } fix_plan_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RD0, S_WR0, S_RD1, S_WR1, S_DONE
    } fix_state_t;

    function automatic fix_plan_t plan_fix(input logic [POS_W-1:0] pos,
                                           input logic [SYM_W-1:0] pat);
        fix_plan_t         p;
        logic [ADDR_W:0]   triple;
        logic [ADDR_W-1:0] idx;
        triple = {2'b00, pos} + {1'b0, pos, 1'b0};
        idx    = triple[ADDR_W:1];
        p      = '0;
        p.bad  = (pos > POS_W'(LAST_POS)) || ((pos == '0) && (pat[11:8] != 4'h0));
        if (pos == '0) begin
            p.addr0 = '0;
            p.mask0 = pat[7:0];
            p.two   = 1'b0;
        end else if (pos[0]) begin
            p.addr0 = idx;
            p.mask0 = pat[11:4];
            p.addr1 = idx + ADDR_W'(1);
            p.mask1 = {pat[3:0], 4'h0};
            p.two   = 1'b1;
        end else begin
            p.addr0 = idx - ADDR_W'(1);
            p.mask0 = {4'h0, pat[11:8]};
            p.addr1 = idx;
            p.mask1 = pat[7:0];
            p.two   = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/ecc_fix_map.sv
module ecc_fix_map
    import ecc_fix_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] pat,
    output fix_plan_t        plan
);

    always_comb plan = plan_fix(pos, pat);

endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
    import ecc_fix_pkg::*;
#(
    parameter int MAX_CORR = 4,
    localparam int CNT_W   = $clog2(MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    input  fix_plan_t         plan_in,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata,
    output logic              done,
    output logic              page_fail,
    output logic [CNT_W-1:0]  fixed_cnt
);

    fix_state_t       st_q;
    fix_plan_t        plan_q;
    logic             last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fail_q;
    logic             full;
    logic             second;

    assign full   = (cnt_q == CNT_W'(MAX_CORR));
    assign second = (st_q == S_RD1) || (st_q == S_WR1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            plan_q <= '0;
            last_q <= 1'b0;
            cnt_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (in_valid) begin
                    plan_q <= plan_in;
                    last_q <= in_last;
                    if (plan_in.bad || full) begin
                        fail_q <= 1'b1;
                        st_q   <= in_last ? S_DONE : S_IDLE;
                    end else begin
                        st_q   <= S_RD0;
                    end
                end
                S_RD0: st_q <= S_WR0;
                S_WR0: if (plan_q.two) begin
                    st_q <= S_RD1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    st_q  <= last_q ? S_DONE : S_IDLE;
                end
                S_RD1: st_q <= S_WR1;
                S_WR1: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    st_q  <= last_q ? S_DONE : S_IDLE;
                end
                default: begin
                    cnt_q  <= '0;
                    fail_q <= 1'b0;
                    st_q   <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        in_ready  = (st_q == S_IDLE);
        buf_rd_en = (st_q == S_RD0) || (st_q == S_RD1);
        buf_wr_en = (st_q == S_WR0) || (st_q == S_WR1);
        buf_addr  = second ? plan_q.addr1 : plan_q.addr0;
        buf_wdata = buf_rdata ^ (second ? plan_q.mask1 : plan_q.mask0);
        done      = (st_q == S_DONE);
        page_fail = fail_q;
        fixed_cnt = cnt_q;
    end

    a_r11_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_results_cleared: assert property (@(posedge clk) disable iff (rst)
        done |=> (fixed_cnt == '0 && !page_fail));

    a_r10_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        fixed_cnt <= CNT_W'(MAX_CORR));

    a_r7_addr_in_parity: assert property (@(posedge clk) disable iff (rst)
        (buf_rd_en || buf_wr_en) |-> (buf_addr < ADDR_W'(MAIN_BYTES + PARITY_BYTES)));

    a_r1_no_access_when_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !buf_wr_en);

endmodule

// File: rtl/ecc_fix_apply.sv
module ecc_fix_apply
    import ecc_fix_pkg::*;
#(
    parameter int MAX_CORR = 4,
    localparam int CNT_W   = $clog2(MAX_CORR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              corr_valid,
    output logic              corr_ready,
    input  logic [POS_W-1:0]  corr_pos,
    input  logic [SYM_W-1:0]  corr_pat,
    input  logic              corr_last,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata,
    output logic              done,
    output logic              page_fail,
    output logic [CNT_W-1:0]  fixed_cnt
);

    fix_plan_t plan;

    ecc_fix_map i_map (
        .pos  (corr_pos),
        .pat  (corr_pat),
        .plan (plan)
    );

    ecc_fix_seq #(.MAX_CORR(MAX_CORR)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (corr_valid),
        .in_ready  (corr_ready),
        .in_last   (corr_last),
        .plan_in   (plan),
        .buf_addr  (buf_addr),
        .buf_rd_en (buf_rd_en),
        .buf_rdata (buf_rdata),
        .buf_wr_en (buf_wr_en),
        .buf_wdata (buf_wdata),
        .done      (done),
        .page_fail (page_fail),
        .fixed_cnt (fixed_cnt)
    );

endmodule

// File: tb/test_ecc_fix_apply.sv
module test_ecc_fix_apply;

    localparam int MEM = 2112;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        corr_valid = 1'b0;
    logic        corr_ready;
    logic [10:0] corr_pos = '0;
    logic [11:0] corr_pat = '0;
    logic        corr_last = 1'b0;
    logic [11:0] buf_addr;
    logic        buf_rd_en;
    logic [7:0]  buf_rdata;
    logic        buf_wr_en;
    logic [7:0]  buf_wdata;
    logic        done;
    logic        page_fail;
    logic [2:0]  fixed_cnt;

    logic [7:0] mem    [MEM];
    logic [7:0] refmem [MEM];
    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    ecc_fix_apply i_ecc_fix_apply (
        .clk(clk), .rst(rst), .corr_valid(corr_valid), .corr_ready(corr_ready),
        .corr_pos(corr_pos), .corr_pat(corr_pat), .corr_last(corr_last),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .done(done),
        .page_fail(page_fail), .fixed_cnt(fixed_cnt)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            if (buf_rd_en) buf_rdata <= mem[buf_addr];
            if (buf_wr_en) mem[buf_addr] <= buf_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // place pattern bits into the MSB-first packed bit stream
    function automatic void ref_apply(input int pos, input int pat);
        int start = (pos == 0) ? 0 : 8 + 12 * (pos - 1);
        int w     = (pos == 0) ? 8 : 12;
        for (int k = 0; k < w; k++) begin
            int s = start + k;
            int b = (pat >> (w - 1 - k)) & 1;
            refmem[s / 8][7 - (s % 8)] = refmem[s / 8][7 - (s % 8)] ^ b[0];
        end
    endfunction

    task automatic run_page(input int n, input int pa[5], input int ta[5], input string req);
        int applied = 0;
        bit efail = 0;
        bit seen;
        for (int i = 0; i < n; i++) begin
            bit ok = (pa[i] <= 1374) && !(pa[i] == 0 && ta[i] > 255) && (applied < 4);
            bit lst = (i == n - 1);
            @(negedge clk);
            corr_valid = 1'b1;
            corr_pos   = 11'(pa[i]);
            corr_pat   = 12'(ta[i]);
            corr_last  = lst;
            while (!corr_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            corr_valid = 1'b0;
            check(corr_ready == !(ok || lst), "R1 ready after accept", int'(corr_ready), int'(!(ok || lst)));
            if (ok) begin
                ref_apply(pa[i], ta[i]);
                applied++;
            end else begin
                efail = 1;
            end
        end
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, {req, " R9 done"}, int'(seen), 1);
        check(int'(fixed_cnt) == applied, {req, " R9 count"}, int'(fixed_cnt), applied);
        check(page_fail == efail, {req, " fail flag"}, int'(page_fail), int'(efail));
        begin
            int bad = -1;
            for (int a = 0; a < MEM; a++)
                if (mem[a] !== refmem[a] && bad < 0) bad = a;
            check(bad < 0, {req, " R11 buffer image"}, (bad < 0) ? 0 : int'(mem[bad]),
                  (bad < 0) ? 0 : int'(refmem[bad]));
            if (bad >= 0) $display("  first differing address %0d", bad);
        end
        @(negedge clk);
        check(!done && fixed_cnt == 0 && !page_fail, {req, " R9 cleared"}, int'(fixed_cnt), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R9: run did not finish, actual 0 expected 1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM; i++) refmem[i] = 8'(i * 7 + 3);
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(corr_ready && !done && !buf_wr_en && !buf_rd_en && fixed_cnt == 0,
              "R1 reset state", int'(corr_ready), 1);

        // R2 R3: short first symbol
        run_page(1, '{0, 0, 0, 0, 0}, '{8'h5A, 0, 0, 0, 0}, "R2 pos0");
        run_page(1, '{0, 0, 0, 0, 0}, '{12'h1AB, 0, 0, 0, 0}, "R3 pos0 wide");
        // R6 R7 R8 boundaries
        run_page(1, '{1365, 0, 0, 0, 0}, '{12'hABC, 0, 0, 0, 0}, "R6 straddle");
        run_page(1, '{1374, 0, 0, 0, 0}, '{12'hFFF, 0, 0, 0, 0}, "R7 last parity");
        run_page(1, '{1375, 0, 0, 0, 0}, '{12'h123, 0, 0, 0, 0}, "R8 beyond");
        // R4 R5 R10: multi-correction pages
        run_page(4, '{1, 2, 3, 4, 0}, '{12'h111, 12'h222, 12'h333, 12'h444, 0}, "R4 R5 four");
        run_page(5, '{10, 11, 12, 13, 14}, '{12'h0F0, 12'hF0F, 12'h5A5, 12'hA5A, 12'hFFF}, "R10 fifth");
        run_page(3, '{7, 2000, 9, 0, 0}, '{12'h777, 12'h001, 12'h999, 0, 0}, "R8 mid invalid");
        run_page(2, '{500, 1500, 0, 0, 0}, '{12'h321, 12'h004, 0, 0, 0}, "R9 last invalid");
        run_page(2, '{800, 800, 0, 0, 0}, '{12'hC3C, 12'hC3C, 0, 0, 0}, "R11 cancel");

        // sweep every position: R4 odd, R5 even, R7 spare, R8 invalid
        for (int p = 1; p <= 1380; p++) begin
            int t = ((p * 173) + 29) & 12'hFFF;
            run_page(1, '{p, 0, 0, 0, 0}, '{t, 0, 0, 0, 0},
                     (p > 1374) ? "R8 sweep" : ((p > 1365) ? "R7 sweep" : ((p % 2) ? "R4 sweep" : "R5 sweep")));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule